// File: doc/BRIEF.md
# Trap Commit Unit

This block is the part of a processor core that retires a trap. When the pipeline raises a trap it presents four things for one cycle: the cause code, the program counter of the trapping instruction, and an optional faulting address with its valid flag. The unit then picks one of four destinations. The trap can start a debug session on a software breakpoint, or it can be bounced to the debug exception handler while a debug session is already active. Otherwise it is taken by supervisor mode when the trap is delegated there, or by machine mode. The unit updates the status stack and the trap registers that belong to the chosen destination. One cycle later it presents the redirect PC and the new privilege level.

The vector bases, the two delegation masks and the per-privilege breakpoint enables arrive as static configuration inputs. A restore port reloads the privilege level and the interrupt-enable bits and ends a debug session, which is the effect of a return instruction. A reservation-set input stands in for a load-reserved. All saved trap state is visible on output ports so that the surrounding core can read it.

Top module: `trap_commit_unit`

## Requirements
- R1: After reset the privilege is M (3), every saved PC, cause and address register is zero, the enable bits, previous-enable bits and previous-privilege fields are zero, the debug cause is zero, the reservation is clear and `npc_vld` is low.
- R2: A trap whose cause equals `BP_CAUSE` (default 3) enters debug when `bp_en[prv]` is set. The debug cause becomes `SWBP_CODE` (default 1), `dprv` gets the old privilege, `dpc` gets `trap_epc`, the privilege becomes M and the redirect PC is `DBG_ROM_ADDR`. No machine or supervisor register changes. When `bp_en[prv]` is clear the breakpoint is routed like any other trap.
- R3: While the debug cause is nonzero, any trap that does not qualify under R2 redirects to `DBG_EXC_ADDR`. Privilege, status bits and every saved trap register stay unchanged.
- R4: A cause with bit XLEN-1 set is an interrupt and is looked up in `ideleg` at the cause index with that bit removed. Any other cause is looked up in `edeleg`.
- R5: A trap goes to S only if the privilege is U (0) or S (1), the cause index is below XLEN, and the looked-up delegation bit is 1. Otherwise it goes to M.
- R6: On S entry the redirect PC is `stvec`, `sepc` and `scause` are written, and `sbad` is written only when `trap_addr_vld` is 1. M entry does the same with `mtvec`, `mepc`, `mcause` and `mbad`.
- R7: On S entry `spie` gets `ie[prv]` (enable bits: bit 0 U, bit 1 S, bit 3 M, bit 2 always 0), `spp` gets bit 0 of the old privilege, `ie[1]` clears and the privilege becomes S.
- R8: On M entry `mpie` gets `ie[prv]`, `mpp` gets the two-bit old privilege, `ie[3]` clears and the privilege becomes M.
- R9: Every trap commit, whatever its destination, clears the reservation. `resv_set` sets it when no trap commits.
- R10: A restore (`ld_valid`) loads the privilege from `ld_prv` and the enable bits from `ld_ie`, with bit 2 ignored, and clears the debug cause. When a trap arrives in the same cycle, the trap is committed and the restore is dropped.
- R11: `npc_vld` is high for exactly the one cycle after each trap cycle, with `npc` and `prv` already updated. At all other times it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_valid | input | 1 | Trap commit strobe |
| trap_cause | input | XLEN | Cause code, top bit marks interrupt |
| trap_addr | input | XLEN | Faulting address |
| trap_addr_vld | input | 1 | Trap carries an address |
| trap_epc | input | XLEN | PC of the trapping instruction |
| stvec | input | XLEN | Supervisor vector base |
| mtvec | input | XLEN | Machine vector base |
| edeleg | input | XLEN | Exception delegation mask |
| ideleg | input | XLEN | Interrupt delegation mask |
| bp_en | input | 4 | Breakpoint-enters-debug enable per privilege |
| ld_valid | input | 1 | Restore strobe |
| ld_prv | input | 2 | Privilege to restore |
| ld_ie | input | 4 | Enable bits to restore |
| resv_set | input | 1 | Set the load reservation |
| npc_vld | output | 1 | Redirect valid |
| npc | output | XLEN | Redirect PC |
| prv | output | 2 | Current privilege |
| ie | output | 4 | Interrupt enable bits |
| spie | output | 1 | Supervisor previous enable |
| spp | output | 1 | Supervisor previous privilege |
| mpie | output | 1 | Machine previous enable |
| mpp | output | 2 | Machine previous privilege |
| sepc | output | XLEN | Supervisor exception PC |
| scause | output | XLEN | Supervisor cause |
| sbad | output | XLEN | Supervisor bad address |
| mepc | output | XLEN | Machine exception PC |
| mcause | output | XLEN | Machine cause |
| mbad | output | XLEN | Machine bad address |
| dcause | output | 3 | Debug cause, nonzero while in debug |
| dprv | output | 2 | Privilege saved on debug entry |
| dpc | output | XLEN | PC saved on debug entry |
| resv_valid | output | 1 | Load reservation held |

## Verification
The bench targets the routing edges. A delegated cause raised from M must still go to M. An exception index at or beyond XLEN must not alias onto a low delegation bit; a design that truncated the index first would send cause 70 to S. An interrupt must be looked up in the interrupt mask, and a mix-up there routes it to the wrong mode. Inside a debug session an ordinary trap, and a breakpoint whose enable is off, must both redirect without touching `mepc` or the privilege; a design that fell through would overwrite the machine registers. The bench also checks that a trap without an address keeps `sbad`, that the previous-enable bit is taken from the privilege being left, and that a restore arriving together with a trap loses to it.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef enum logic [1:0] {
    PRV_U = 2'd0,
    PRV_S = 2'd1,
    PRV_H = 2'd2,
    PRV_M = 2'd3
  } priv_e;

  typedef enum logic [2:0] {
    DST_NONE,
    DST_DBG_ENTER,
    DST_DBG_EXC,
    DST_SUP,
    DST_MACH
  } dest_e;
endpackage

// File: rtl/trap_route.sv
module trap_route
  import trap_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter int BP_CAUSE = 3
) (
  input  logic            trap_vld,
  input  logic [XLEN-1:0] cause,
  input  logic [1:0]      cur_prv,
  input  logic            dbg_busy,
  input  logic [3:0]      bp_en,
  input  logic [XLEN-1:0] edeleg,
  input  logic [XLEN-1:0] ideleg,
  output dest_e           dest
);
  localparam int              IW     = $clog2(XLEN);
  localparam logic [XLEN-1:0] XLEN_W = XLEN;
  localparam logic [XLEN-1:0] BP_W   = XLEN'(BP_CAUSE);

  logic            is_irq;
  logic [XLEN-1:0] cause_lo;
  logic [XLEN-1:0] sel_mask;
  logic            in_range;
  logic            dbit;
  logic            bp_hit;

  always_comb begin
    is_irq   = cause[XLEN-1];
    cause_lo = {1'b0, cause[XLEN-2:0]};
    sel_mask = is_irq ? ideleg : edeleg;
    in_range = cause_lo < XLEN_W;
    dbit     = sel_mask[cause_lo[IW-1:0]];
    bp_hit   = (cause == BP_W) && bp_en[cur_prv];
    dest     = DST_NONE;
    if (trap_vld) begin
      if (bp_hit)                                        dest = DST_DBG_ENTER;
      else if (dbg_busy)                                 dest = DST_DBG_EXC;
      else if ((cur_prv <= PRV_S) && in_range && dbit)   dest = DST_SUP;
      else                                               dest = DST_MACH;
    end
  end
endmodule

// File: rtl/trap_mode_bank.sv
module trap_mode_bank #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic [XLEN-1:0] epc_in,
  input  logic [XLEN-1:0] cause_in,
  input  logic [XLEN-1:0] addr_in,
  input  logic            addr_vld,
  output logic [XLEN-1:0] epc_q,
  output logic [XLEN-1:0] cause_q,
  output logic [XLEN-1:0] bad_q
);
  logic [XLEN-1:0] epc_d, cause_d, bad_d;
  logic            bad_en;

  always_comb begin
    bad_en  = take && addr_vld;
    epc_d   = take   ? epc_in   : epc_q;
    cause_d = take   ? cause_in : cause_q;
    bad_d   = bad_en ? addr_in  : bad_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc_q   <= '0;
      cause_q <= '0;
      bad_q   <= '0;
    end else begin
      epc_q   <= epc_d;
      cause_q <= cause_d;
      bad_q   <= bad_d;
    end
  end

  // R6: an address-less trap leaves the bad-address register alone
  a_r6_bad_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !addr_vld) |=> $stable(bad_q));
  // R6: the exception PC captured is the one presented with the trap
  a_r6_epc_capture: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (epc_q == $past(epc_in)));
endmodule

// File: rtl/trap_dbg_state.sv
module trap_dbg_state #(
  parameter int XLEN      = 64,
  parameter int SWBP_CODE = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enter,
  input  logic            clr,
  input  logic [1:0]      cur_prv,
  input  logic [XLEN-1:0] epc_in,
  output logic [2:0]      dcause_q,
  output logic [1:0]      dprv_q,
  output logic [XLEN-1:0] dpc_q,
  output logic            busy
);
  localparam logic [2:0] SWBP_W = 3'(SWBP_CODE);

  logic [2:0]      dcause_d;
  logic [1:0]      dprv_d;
  logic [XLEN-1:0] dpc_d;

  always_comb begin
    dcause_d = dcause_q;
    dprv_d   = dprv_q;
    dpc_d    = dpc_q;
    if (enter) begin
      dcause_d = SWBP_W;
      dprv_d   = cur_prv;
      dpc_d    = epc_in;
    end else if (clr) begin
      dcause_d = '0;
    end
    busy = (dcause_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcause_q <= '0;
      dprv_q   <= '0;
      dpc_q    <= '0;
    end else begin
      dcause_q <= dcause_d;
      dprv_q   <= dprv_d;
      dpc_q    <= dpc_d;
    end
  end

  // R2: entering debug records the software-breakpoint cause and old privilege
  a_r2_enter_cause: assert property (@(posedge clk) disable iff (!rst_n)
    enter |=> (dcause_q == SWBP_W) && (dprv_q == $past(cur_prv)));
  // R10: a restore with no trap ends the debug session
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !enter) |=> (dcause_q == 3'd0));
endmodule

// File: rtl/trap_commit_unit.sv
module trap_commit_unit
  import trap_pkg::*;
#(
  parameter int              XLEN         = 64,
  parameter logic [XLEN-1:0] DBG_ROM_ADDR = 'h800,
  parameter logic [XLEN-1:0] DBG_EXC_ADDR = 'h808,
  parameter int              BP_CAUSE     = 3,
  parameter int              SWBP_CODE    = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trap_valid,
  input  logic [XLEN-1:0] trap_cause,
  input  logic [XLEN-1:0] trap_addr,
  input  logic            trap_addr_vld,
  input  logic [XLEN-1:0] trap_epc,
  input  logic [XLEN-1:0] stvec,
  input  logic [XLEN-1:0] mtvec,
  input  logic [XLEN-1:0] edeleg,
  input  logic [XLEN-1:0] ideleg,
  input  logic [3:0]      bp_en,
  input  logic            ld_valid,
  input  logic [1:0]      ld_prv,
  input  logic [3:0]      ld_ie,
  input  logic            resv_set,
  output logic            npc_vld,
  output logic [XLEN-1:0] npc,
  output logic [1:0]      prv,
  output logic [3:0]      ie,
  output logic            spie,
  output logic            spp,
  output logic            mpie,
  output logic [1:0]      mpp,
  output logic [XLEN-1:0] sepc,
  output logic [XLEN-1:0] scause,
  output logic [XLEN-1:0] sbad,
  output logic [XLEN-1:0] mepc,
  output logic [XLEN-1:0] mcause,
  output logic [XLEN-1:0] mbad,
  output logic [2:0]      dcause,
  output logic [1:0]      dprv,
  output logic [XLEN-1:0] dpc,
  output logic            resv_valid
);
  localparam int         NBANK   = 2;
  localparam logic [3:0] IE_MASK = 4'b1011;

  dest_e           dest;
  logic            dbg_busy;
  logic [XLEN-1:0] bank_epc   [NBANK];
  logic [XLEN-1:0] bank_cause [NBANK];
  logic [XLEN-1:0] bank_bad   [NBANK];

  logic [1:0]      prv_q, prv_d;
  logic [3:0]      ie_q, ie_d;
  logic            spie_q, spie_d, spp_q, spp_d, mpie_q, mpie_d;
  logic [1:0]      mpp_q, mpp_d;
  logic [XLEN-1:0] npc_q, npc_d;
  logic            npc_vld_q, npc_vld_d;
  logic            resv_q, resv_d;

  trap_route #(.XLEN(XLEN), .BP_CAUSE(BP_CAUSE)) u_route (
    .trap_vld (trap_valid),
    .cause    (trap_cause),
    .cur_prv  (prv_q),
    .dbg_busy (dbg_busy),
    .bp_en    (bp_en),
    .edeleg   (edeleg),
    .ideleg   (ideleg),
    .dest     (dest)
  );

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    localparam dest_e MY_DEST = (g == 0) ? DST_SUP : DST_MACH;
    trap_mode_bank #(.XLEN(XLEN)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (dest == MY_DEST),
      .epc_in   (trap_epc),
      .cause_in (trap_cause),
      .addr_in  (trap_addr),
      .addr_vld (trap_addr_vld),
      .epc_q    (bank_epc[g]),
      .cause_q  (bank_cause[g]),
      .bad_q    (bank_bad[g])
    );
  end

  trap_dbg_state #(.XLEN(XLEN), .SWBP_CODE(SWBP_CODE)) u_dbg (
    .clk      (clk),
    .rst_n    (rst_n),
    .enter    (dest == DST_DBG_ENTER),
    .clr      (ld_valid && !trap_valid),
    .cur_prv  (prv_q),
    .epc_in   (trap_epc),
    .dcause_q (dcause),
    .dprv_q   (dprv),
    .dpc_q    (dpc),
    .busy     (dbg_busy)
  );

  always_comb begin
    prv_d     = prv_q;
    ie_d      = ie_q;
    spie_d    = spie_q;
    spp_d     = spp_q;
    mpie_d    = mpie_q;
    mpp_d     = mpp_q;
    npc_d     = npc_q;
    npc_vld_d = (dest != DST_NONE);
    resv_d    = resv_q;
    if (ld_valid && !trap_valid) begin
      prv_d = ld_prv;
      ie_d  = ld_ie & IE_MASK;
    end
    if (dest != DST_NONE) resv_d = 1'b0;
    else if (resv_set)    resv_d = 1'b1;
    unique case (dest)
      DST_DBG_ENTER: begin
        npc_d = DBG_ROM_ADDR;
        prv_d = PRV_M;
      end
      DST_DBG_EXC: npc_d = DBG_EXC_ADDR;
      DST_SUP: begin
        npc_d   = stvec;
        spie_d  = ie_q[prv_q];
        spp_d   = prv_q[0];
        ie_d[1] = 1'b0;
        prv_d   = PRV_S;
      end
      DST_MACH: begin
        npc_d   = mtvec;
        mpie_d  = ie_q[prv_q];
        mpp_d   = prv_q;
        ie_d[3] = 1'b0;
        prv_d   = PRV_M;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prv_q     <= PRV_M;
      ie_q      <= '0;
      spie_q    <= 1'b0;
      spp_q     <= 1'b0;
      mpie_q    <= 1'b0;
      mpp_q     <= '0;
      npc_q     <= '0;
      npc_vld_q <= 1'b0;
      resv_q    <= 1'b0;
    end else begin
      prv_q     <= prv_d;
      ie_q      <= ie_d;
      spie_q    <= spie_d;
      spp_q     <= spp_d;
      mpie_q    <= mpie_d;
      mpp_q     <= mpp_d;
      npc_q     <= npc_d;
      npc_vld_q <= npc_vld_d;
      resv_q    <= resv_d;
    end
  end

  assign npc_vld    = npc_vld_q;
  assign npc        = npc_q;
  assign prv        = prv_q;
  assign ie         = ie_q;
  assign spie       = spie_q;
  assign spp        = spp_q;
  assign mpie       = mpie_q;
  assign mpp        = mpp_q;
  assign sepc       = bank_epc[0];
  assign scause     = bank_cause[0];
  assign sbad       = bank_bad[0];
  assign mepc       = bank_epc[1];
  assign mcause     = bank_cause[1];
  assign mbad       = bank_bad[1];
  assign resv_valid = resv_q;

  // R3: a redirect inside debug keeps privilege and machine registers
  a_r3_redirect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (dest == DST_DBG_EXC) |=> (npc_q == DBG_EXC_ADDR) && $stable(prv_q) && $stable(mepc));
  // R7: supervisor entry stacks the old privilege and clears the S enable
  a_r7_sup_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (dest == DST_SUP) |=> (prv_q == PRV_S) && !ie_q[1] && (spp_q == $past(prv_q[0])));
  // R8: machine entry stacks the old privilege and clears the M enable
  a_r8_mach_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (dest == DST_MACH) |=> (prv_q == PRV_M) && !ie_q[3] && (mpp_q == $past(prv_q)));
  // R5: a trap raised in M is never handed to S
  a_r5_no_sup_from_m: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && prv_q == PRV_M) |-> (dest != DST_SUP));
  // R9: any trap commit drops the reservation
  a_r9_resv_drop: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |=> !resv_q);
  // R11: the redirect strobe follows only a trap cycle
  a_r11_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_valid |=> !npc_vld_q);
endmodule

// File: tb/trap_commit_unit_test.sv
module trap_commit_unit_test;
  localparam int          XLEN = 64;
  localparam logic [63:0] STV  = 64'h1000_0100;
  localparam logic [63:0] MTV  = 64'h2000_0200;
  localparam logic [63:0] ROM  = 64'h800;
  localparam logic [63:0] DEXC = 64'h808;
  localparam logic [63:0] IRQ  = 64'h1 << 63;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trap_valid = 1'b0, trap_addr_vld = 1'b0;
  logic [63:0] trap_cause = '0, trap_addr = '0, trap_epc = '0;
  logic [63:0] stvec = STV, mtvec = MTV;
  logic [63:0] edeleg = (64'h1 << 2) | (64'h1 << 8) | (64'h1 << 6);
  logic [63:0] ideleg = 64'h1 << 5;
  logic [3:0]  bp_en = 4'b0000;
  logic        ld_valid = 1'b0;
  logic [1:0]  ld_prv = '0;
  logic [3:0]  ld_ie = '0;
  logic        resv_set = 1'b0;
  logic        npc_vld, spie, spp, mpie, resv_valid;
  logic [63:0] npc, sepc, scause, sbad, mepc, mcause, mbad, dpc;
  logic [1:0]  prv, mpp, dprv;
  logic [3:0]  ie;
  logic [2:0]  dcause;

  trap_commit_unit #(.XLEN(XLEN)) uut (.*);

  always #5 clk = ~clk;

  typedef struct {
    logic [63:0] pc;
    logic [1:0]  pv;
    string       tag;
  } exp_t;

  exp_t q[$];
  exp_t e;
  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected redirect per strobe
  always @(negedge clk) begin
    if (rst_n && npc_vld) begin
      if (q.size() == 0) begin
        chk("R11 unexpected npc_vld", 64'(npc_vld), 64'd0);
      end else begin
        e = q.pop_front();
        chk({e.tag, " npc"}, npc, e.pc);
        chk({e.tag, " prv"}, 64'(prv), 64'(e.pv));
      end
    end
  end

  task automatic do_ld(logic [1:0] p, logic [3:0] b);
    ld_valid = 1'b1; ld_prv = p; ld_ie = b;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic do_trap(logic [63:0] c, logic [63:0] a, logic av, logic [63:0] pc,
                         logic [63:0] xpc, logic [1:0] xpv, string tag);
    exp_t it;
    it.pc = xpc; it.pv = xpv; it.tag = tag;
    q.push_back(it);
    trap_valid = 1'b1; trap_cause = c; trap_addr = a; trap_addr_vld = av; trap_epc = pc;
    @(negedge clk);
    trap_valid = 1'b0; trap_addr_vld = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 prv", 64'(prv), 64'd3);
    chk("R1 mcause", mcause, 64'd0);
    chk("R1 sepc", sepc, 64'd0);
    chk("R1 dcause", 64'(dcause), 64'd0);
    chk("R1 resv", 64'(resv_valid), 64'd0);
    chk("R1 npc_vld", 64'(npc_vld), 64'd0);
    chk("R1 ie", 64'(ie), 64'd0);

    // R10 restore, R8 machine entry from M even though delegated (R5)
    do_ld(2'd3, 4'b1000);
    chk("R10 ie load", 64'(ie), 64'h8);
    do_trap(64'd2, 64'h55, 1'b1, 64'h100, MTV, 2'd3, "R5 M stays M");
    chk("R8 mepc", mepc, 64'h100);
    chk("R8 mcause", mcause, 64'd2);
    chk("R6 mbad", mbad, 64'h55);
    chk("R8 mpp", 64'(mpp), 64'd3);
    chk("R8 mpie", 64'(mpie), 64'd1);
    chk("R8 mie clr", 64'(ie[3]), 64'd0);

    // R6/R7 delegated exception from U, no address
    do_ld(2'd0, 4'b0010);
    do_trap(64'd8, 64'h77, 1'b0, 64'h200, STV, 2'd1, "R7 U to S");
    chk("R6 scause", scause, 64'd8);
    chk("R6 sepc", sepc, 64'h200);
    chk("R6 sbad kept", sbad, 64'd0);
    chk("R7 spp", 64'(spp), 64'd0);
    chk("R7 spie", 64'(spie), 64'd0);
    chk("R7 sie clr", 64'(ie[1]), 64'd0);

    do_ld(2'd1, 4'b0010);
    do_trap(64'd8, 64'h0, 1'b0, 64'h300, STV, 2'd1, "R7 S to S");
    chk("R7 spie from S", 64'(spie), 64'd1);
    chk("R7 spp from S", 64'(spp), 64'd1);

    // R4 interrupt uses ideleg, exception with same index uses edeleg
    do_ld(2'd0, 4'b0000);
    do_trap(IRQ | 64'd5, 64'h99, 1'b1, 64'h400, STV, 2'd1, "R4 irq delegated");
    chk("R4 scause", scause, IRQ | 64'd5);
    chk("R6 sbad", sbad, 64'h99);
    do_ld(2'd0, 4'b0000);
    do_trap(64'd5, 64'h0, 1'b0, 64'h500, MTV, 2'd3, "R4 exc not delegated");
    chk("R4 mcause", mcause, 64'd5);
    chk("R8 mpp from U", 64'(mpp), 64'd0);

    // R5 cause index beyond XLEN must not alias to bit 6
    do_ld(2'd0, 4'b0000);
    do_trap(64'd70, 64'h0, 1'b0, 64'h600, MTV, 2'd3, "R5 index out of range");
    chk("R5 mcause 70", mcause, 64'd70);

    // R9 reservation
    do_ld(2'd0, 4'b0000);
    resv_set = 1'b1; @(negedge clk); resv_set = 1'b0;
    chk("R9 resv set", 64'(resv_valid), 64'd1);
    do_trap(64'd8, 64'h0, 1'b0, 64'h610, STV, 2'd1, "R9 trap");
    chk("R9 resv dropped", 64'(resv_valid), 64'd0);

    // R2 breakpoint with enable off for U behaves normally
    bp_en = 4'b0010;
    do_ld(2'd0, 4'b0000);
    do_trap(64'd3, 64'h0, 1'b0, 64'h700, MTV, 2'd3, "R2 bp disabled");
    chk("R2 no debug", 64'(dcause), 64'd0);
    chk("R2 mepc normal", mepc, 64'h700);

    // R2 breakpoint with enable on for S enters debug
    do_ld(2'd1, 4'b0000);
    do_trap(64'd3, 64'h0, 1'b0, 64'h710, ROM, 2'd3, "R2 debug entry");
    chk("R2 dcause", 64'(dcause), 64'd1);
    chk("R2 dprv", 64'(dprv), 64'd1);
    chk("R2 dpc", dpc, 64'h710);
    chk("R2 mepc untouched", mepc, 64'h700);

    // R3 redirects inside debug
    resv_set = 1'b1; @(negedge clk); resv_set = 1'b0;
    do_trap(64'd2, 64'h33, 1'b1, 64'h720, DEXC, 2'd3, "R3 redirect");
    chk("R3 mepc", mepc, 64'h700);
    chk("R3 mcause", mcause, 64'd3);
    chk("R3 mbad", mbad, 64'h55);
    chk("R3 dpc", dpc, 64'h710);
    chk("R9 resv after redirect", 64'(resv_valid), 64'd0);
    do_trap(64'd3, 64'h0, 1'b0, 64'h730, DEXC, 2'd3, "R3 bp disabled in M");
    chk("R3 dpc kept", dpc, 64'h710);

    // R10 restore ends debug, bit 2 ignored
    do_ld(2'd1, 4'b1110);
    chk("R10 dcause cleared", 64'(dcause), 64'd0);
    chk("R10 prv", 64'(prv), 64'd1);
    chk("R10 ie bit2", 64'(ie), 64'ha);

    // R10 trap beats a simultaneous restore
    ld_valid = 1'b1; ld_prv = 2'd0; ld_ie = 4'b0000;
    do_trap(64'd11, 64'h0, 1'b0, 64'h800, MTV, 2'd3, "R10 trap wins");
    ld_valid = 1'b0;
    chk("R10 mpp old prv", 64'(mpp), 64'd1);
    chk("R10 mpie", 64'(mpie), 64'd1);

    // R11 strobe quiet when idle
    repeat (3) @(negedge clk);
    chk("R11 idle", 64'(npc_vld), 64'd0);
    chk("R11 queue drained", 64'(q.size()), 64'd0);
    finish_run();
  end
endmodule